// File: doc/BRIEF.md
# Line-Frequency Time-Base Divider

This block turns a mains-derived square wave into a slow time-base signal. The line signal is already a clean digital level. It is synchronous to the system clock, and each of its falling edges counts as one event. A chain of small Johnson counters divides the event count, and the most significant flip-flop of the last stage drives the output. Every stage in the chain runs on the system clock.

One input tells the block whether the line runs at 50 Hz or 60 Hz. The block then picks the smaller or the larger ratio of its pair, so the output has the same period on either mains frequency. A build-time parameter chooses which of the six ratio pairs the chain implements. An enable input freezes the count. A clear input zeroes every stage.

The first stage divides by five or by six. The later stages have fixed lengths: divide-by-ten, divide-by-six and divide-by-two. Each later stage steps only in the clock cycle in which the stage before it wraps.

Top module: `ltb_divider`

## Requirements
- R1: While `rst_n` is low, and after it is released, every stage holds zero and `tick_out` is 0.
- R2: A counted event is a clock cycle in which `line_in` is sampled low after it was sampled high in the previous cycle. The stages update at that clock edge. A rising edge of `line_in` changes nothing.
- R3: With `sel_50` = 1 the output period is the smaller ratio of the pair, counted in line events. With `sel_50` = 0 it is the larger ratio.
- R4: After a clear, `tick_out` is low for the first N/2 events of each period, rounded down, and high for the rest. For every variant except 5/6 this gives an exact 50% duty. In 5/6 with `sel_50` = 1 the output is low for 2 events and high for 3.
- R5: Falling line edges that arrive while `cnt_en` is 0 are ignored. Every stage holds its state, and so does `tick_out`.
- R6: `clr` = 1 zeroes every stage at the next clock edge, whatever `cnt_en` is. Line events are ignored while `clr` is high.
- R7: The first stage reads `sel_50` at the event that moves it out of its zero state. That value sets the length of the stage's current cycle, five when 1 and six when 0. A change in `sel_50` during a cycle therefore takes effect from the next cycle, and the later stages are not reset.
- R8: The parameter `VARIANT` selects the pair 5/6, 50/60, 100/120, 300/360, 500/600 or 3000/3600. It does so by appending, after the first stage: nothing; a divide-by-10; a divide-by-10 then a divide-by-2; a divide-by-10 then a divide-by-6; two divide-by-10s; or a divide-by-10, a divide-by-6 and a divide-by-10.
- R9: A later stage steps only in a cycle in which the stage before it wraps.
- R10: The first stage visits only legal states. In six-mode these are 000, 001, 011, 111, 110 and 100. In five-mode the stage skips 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Synchronised line square wave; a falling edge is one event |
| cnt_en | input | 1 | Count enable; change it only while line_in is low |
| clr | input | 1 | Synchronous clear of all stages |
| sel_50 | input | 1 | 1 selects the 50 Hz (smaller) ratio, 0 the 60 Hz one |
| tick_out | output | 1 | Time-base square wave |

## Verification
Every counted event takes effect at the first rising clock edge at which `line_in` is seen low after being high. The new `tick_out` is therefore valid one edge after the line falls, and a clear is visible one edge after `clr` is sampled high. The bench lowers the line on a falling clock edge, waits for one rising edge, and compares the outputs at the next falling edge. Rising-edge and frozen-enable checks are sampled several clock cycles later, so that any late change would be seen.

// File: rtl/ltb_pkg.sv
package ltb_pkg;

  typedef enum logic [2:0] {
    V_5_6       = 3'd0,
    V_50_60     = 3'd1,
    V_100_120   = 3'd2,
    V_300_360   = 3'd3,
    V_500_600   = 3'd4,
    V_3000_3600 = 3'd5
  } ltb_variant_e;

  localparam int MAX_LATER = 3;
  localparam int FIRST_W   = 3;

  // Number of stages appended after the selectable first stage.
  function automatic int later_count(ltb_variant_e v);
    case (v)
      V_5_6:       return 0;
      V_50_60:     return 1;
      V_100_120:   return 2;
      V_300_360:   return 2;
      V_500_600:   return 2;
      default:     return 3;
    endcase
  endfunction

  // Johnson width of later stage idx (1-based); 0 when absent.
  // Width 1 is a toggle (divide by 2).
  function automatic int later_width(ltb_variant_e v, int idx);
    if (idx < 1 || idx > later_count(v)) return 0;
    if (idx == 1) return 5;
    case (v)
      V_100_120:   return 1;
      V_300_360:   return 3;
      V_500_600:   return 5;
      V_3000_3600: return (idx == 2) ? 3 : 5;
      default:     return 0;
    endcase
  endfunction

  // Division length of a Johnson stage of width w.
  function automatic int johnson_len(int w);
    return (w == 1) ? 2 : 2 * w;
  endfunction

endpackage

// File: rtl/ltb_edge_det.sv
module ltb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_fall
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_in;
  end

  assign line_fall = line_q & ~line_in;
endmodule

// File: rtl/ltb_first_stage.sv
module ltb_first_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       sel_50,
  output logic [2:0] q,
  output logic       mode5,
  output logic       carry
);
  localparam logic [2:0] ST_ZERO = 3'b000;
  localparam logic [2:0] ST_ONE  = 3'b001;
  localparam logic [2:0] ST_LAST = 3'b100;

  logic [2:0] q_nx;

  always_comb begin
    if (q == ST_ONE && mode5) q_nx = 3'b111;
    else                      q_nx = {q[1:0], ~q[2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= ST_ZERO;
      mode5 <= 1'b0;
    end else if (clr) begin
      q     <= ST_ZERO;
    end else if (step) begin
      q <= q_nx;
      if (q == ST_ZERO) mode5 <= sel_50;
    end
  end

  assign carry = step && (q == ST_LAST);
endmodule

// File: rtl/ltb_johnson.sv
module ltb_johnson #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LAST = {1'b1, {(W-1){1'b0}}} >> 0;

  logic [W-1:0] q_nx;

  generate
    if (W == 1) begin : g_toggle
      assign q_nx = ~q;
    end else begin : g_shift
      assign q_nx = {q[W-2:0], ~q[W-1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (step) q <= q_nx;
  end

  assign carry = step && (q == LAST);
endmodule

// File: rtl/ltb_divider.sv
module ltb_divider
  import ltb_pkg::*;
#(
  parameter ltb_variant_e VARIANT = V_100_120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic cnt_en,
  input  logic clr,
  input  logic sel_50,
  output logic tick_out
);
  localparam int N_LATER = later_count(VARIANT);

  logic       line_fall;
  logic       adv;
  logic [2:0] s0_state;
  logic       s0_mode5;
  logic [MAX_LATER:0] stage_carry;
  logic [MAX_LATER:0] stage_msb;

  ltb_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_fall (line_fall)
  );

  assign adv = line_fall && cnt_en && !clr;

  ltb_first_stage u_first (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .step   (adv),
    .sel_50 (sel_50),
    .q      (s0_state),
    .mode5  (s0_mode5),
    .carry  (stage_carry[0])
  );
  assign stage_msb[0] = s0_state[FIRST_W-1];

  generate
    for (genvar i = 1; i <= MAX_LATER; i++) begin : g_later
      localparam int SW = later_width(VARIANT, i);
      if (SW > 0) begin : g_on
        logic [SW-1:0] sq;
        ltb_johnson #(.W(SW)) u_stage (
          .clk   (clk),
          .rst_n (rst_n),
          .clr   (clr),
          .step  (stage_carry[i-1]),
          .q     (sq),
          .carry (stage_carry[i])
        );
        assign stage_msb[i] = sq[SW-1];
      end else begin : g_off
        assign stage_carry[i] = 1'b0;
        assign stage_msb[i]   = 1'b0;
      end
    end
  endgenerate

  assign tick_out = stage_msb[N_LATER];
endmodule

// File: rtl/ltb_divider_chk.sv
module ltb_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       adv,
  input logic       s0_mode5,
  input logic [2:0] s0_state,
  input logic [3:0] stage_carry,
  input logic       tick_out
);
  a_r6_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s0_state == 3'b000 && tick_out == 1'b0));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> ($stable(s0_state) && $stable(tick_out)));

  a_r2_event_moves: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (s0_state != $past(s0_state)));

  a_r9_carry_chain1: assert property (@(posedge clk) disable iff (!rst_n)
    stage_carry[1] |-> stage_carry[0]);
  a_r9_carry_chain2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_carry[2] |-> stage_carry[1]);
  a_r9_carry_chain3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_carry[3] |-> stage_carry[2]);

  a_r10_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    s0_state != 3'b010 && s0_state != 3'b101);

  a_r7_skip_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s0_state == 3'b001) |=>
      (s0_state == ($past(s0_mode5) ? 3'b111 : 3'b011)));

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (tick_out == 1'b0));
endmodule

bind ltb_divider ltb_divider_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .adv         (adv),
  .s0_mode5    (s0_mode5),
  .s0_state    (s0_state),
  .stage_carry (stage_carry),
  .tick_out    (tick_out)
);

// File: tb/ltb_divider_tb_top.sv
module ltb_divider_tb_top;
  import ltb_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, line_in, cnt_en, clr, sel_50;
  logic out_a, out_b;

  ltb_divider #(.VARIANT(V_100_120)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cnt_en(cnt_en),
    .clr(clr), .sel_50(sel_50), .tick_out(out_a));

  ltb_divider #(.VARIANT(V_5_6)) dut5_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cnt_en(cnt_en),
    .clr(clr), .sel_50(sel_50), .tick_out(out_b));

  int errors = 0;
  int checks = 0;

  // Independent model: position in a six-slot first-stage sequence,
  // wraps of the first stage, and the latched length choice.
  int  pos = 0;
  int  wraps = 0;
  bit  five = 1'b0;
  localparam int LATER_PROD_A = 20; // divide-by-10 then divide-by-2

  function automatic bit exp_a();
    return (wraps % LATER_PROD_A) >= (LATER_PROD_A / 2);
  endfunction
  function automatic bit exp_b();
    return pos >= 3;
  endfunction

  task automatic model_event();
    int old;
    old = pos;
    if (pos == 0) five = sel_50;
    if (pos == 1 && five) pos = 3;
    else pos = (pos + 1) % 6;
    if (old == 5) wraps++;
  endtask

  task automatic model_zero();
    pos = 0;
    wraps = 0;
  endtask

  task automatic check(input logic act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (pos=%0d wraps=%0d)", req, act, exp, pos, wraps);
    end
  endtask

  // One line period: high two clocks, then low; checked after the fall.
  task automatic pulse(input string req);
    bit counted;
    @(negedge clk) line_in = 1'b1;
    @(negedge clk);
    @(negedge clk) line_in = 1'b0;
    counted = cnt_en && !clr;
    @(posedge clk);
    if (clr) model_zero();
    else if (counted) model_event();
    @(negedge clk);
    check(out_a, exp_a(), req);
    check(out_b, exp_b(), req);
  endtask

  typedef struct packed {
    logic       sel;
    logic       en;
    logic       cl;
    logic [9:0] n;
  } step_t;

  localparam int NSTEP = 9;
  localparam step_t STEPS [NSTEP] = '{
    '{sel: 1'b1, en: 1'b1, cl: 1'b0, n: 10'd250},  // R3 R4 50 Hz ratio
    '{sel: 1'b0, en: 1'b1, cl: 1'b0, n: 10'd360},  // R3 R4 60 Hz ratio
    '{sel: 1'b0, en: 1'b0, cl: 1'b0, n: 10'd40},   // R5 frozen
    '{sel: 1'b1, en: 1'b1, cl: 1'b0, n: 10'd77},   // R7 switch mid count
    '{sel: 1'b0, en: 1'b1, cl: 1'b1, n: 10'd10},   // R6 clear held
    '{sel: 1'b0, en: 1'b1, cl: 1'b0, n: 10'd130},  // R4 after clear
    '{sel: 1'b1, en: 1'b0, cl: 1'b0, n: 10'd5},    // R5
    '{sel: 1'b1, en: 1'b0, cl: 1'b1, n: 10'd3},    // R6 clear with enable low
    '{sel: 1'b1, en: 1'b1, cl: 1'b0, n: 10'd123}   // R3 R8
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit hold_a, hold_b;
    rst_n = 1'b0; line_in = 1'b0; cnt_en = 1'b0; clr = 1'b0; sel_50 = 1'b1;
    repeat (3) @(negedge clk);
    check(out_a, 1'b0, "R1 in reset");
    check(out_b, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(out_a, 1'b0, "R1 after release");
    check(out_b, 1'b0, "R1 after release");
    cnt_en = 1'b1;

    for (int s = 0; s < NSTEP; s++) begin
      sel_50 = STEPS[s].sel;
      cnt_en = STEPS[s].en;
      clr    = STEPS[s].cl;
      for (int k = 0; k < int'(STEPS[s].n); k++) pulse("R3/R4/R5/R6 table");
    end
    clr = 1'b0;

    // R7: change select one event into a six-length first-stage cycle.
    clr = 1'b1; pulse("R6 clear");
    clr = 1'b0; sel_50 = 1'b0; cnt_en = 1'b1;
    pulse("R7 first event");
    sel_50 = 1'b1;
    for (int k = 0; k < 4; k++) pulse("R7 current cycle stays six");
    check(out_b, 1'b1, "R7 still high before sixth event");
    pulse("R7 wrap");
    check(out_b, 1'b0, "R7 wrapped after six");
    for (int k = 0; k < 2; k++) pulse("R7 next cycle is five");
    check(out_b, 1'b1, "R7 five-mode high after two");

    // R2: a rising edge alone changes nothing.
    hold_a = exp_a(); hold_b = exp_b();
    @(negedge clk) line_in = 1'b1;
    repeat (3) @(negedge clk);
    check(out_a, hold_a, "R2 rising edge ignored");
    check(out_b, hold_b, "R2 rising edge ignored");
    @(negedge clk) line_in = 1'b0;
    @(posedge clk); model_event();
    @(negedge clk);
    check(out_a, exp_a(), "R2 falling edge counted");
    check(out_b, exp_b(), "R2 falling edge counted");

    // R8: full 100/120 period boundary with the 50 Hz ratio.
    clr = 1'b1; pulse("R6 clear");
    clr = 1'b0; sel_50 = 1'b1;
    for (int k = 0; k < 49; k++) pulse("R8 first half");
    check(out_a, 1'b0, "R8 low before event 50");
    pulse("R8 event 50");
    check(out_a, 1'b1, "R8 high at event 50");
    for (int k = 0; k < 50; k++) pulse("R8 second half");
    check(out_a, 1'b0, "R8 period of 100");

    // R1: asynchronous reset in mid count.
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(out_a, 1'b0, "R1 async reset");
    check(out_b, 1'b0, "R1 async reset");
    model_zero();
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < 12; k++) pulse("R1 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule